// File: doc/BRIEF.md
# Machine-cycle clock burst sequencer

This block turns a start request into exactly one machine cycle of a bit-serial processor. The cycle is a burst of clock enables rather than a gated physical clock. The request is an active-low input, sampled on the clock edge. It sets a gate flag, and the gate flag lets a 4-bit phase counter step from 0 to 15. Two clock enables come out of the same counter. A long enable stays high for all 16 phases and shifts a 16-bit serial program counter. A short enable is blocked once the counter's top bit is set, so the 8-bit serial registers get only 8 pulses.

The terminal phase is registered to give a load strobe in the cycle after the burst, together with its complement as a running indication. A carry-preset strobe marks the first phase of each burst. An active-low select follows the inverse of the gate flag for serial peripherals. The block also has a free-run mode, which starts a new burst at once after each one ends. Without free-run, the block waits for a new request.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low and after it is released with no request: `gate` is 0, `sel_n` is 1, `phase` is 0, `pc_ce` and `reg_ce` are 0, `t0` is 0 and `run` is 1.
- R2: `start_n` low at a rising clock edge while idle starts a burst in the next cycle. That first cycle has `phase` 0, `gate` 1 and `sel_n` 0.
- R3: `pc_ce` is high for exactly 16 consecutive cycles per burst, and `sel_n` is always its inverse.
- R4: `reg_ce` is high for exactly 8 cycles per burst: the first 8, where `phase` bit 3 is 0.
- R5: `tc` is high only in the last cycle of a burst (`phase` 15).
- R6: `t0` is high for the one cycle after each terminal cycle, and `run` is always the inverse of `t0`.
- R7: `t1` is high only in the first cycle of each burst (`phase` 0).
- R8: With `free_run` 0 and no new request, the block returns to idle after one burst and stays there.
- R9: `start_n` held low during a burst's non-terminal cycles has no effect. That burst still gives exactly 16 `pc_ce` pulses.
- R10: With `free_run` 1, a new burst begins in the cycle right after the terminal cycle, so `pc_ce` has no idle gap. Clearing `free_run` lets the current burst finish and then stop.
- R11: `start_n` low in the terminal cycle starts the next burst back-to-back, and it takes priority over the end of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Active-low burst request |
| free_run | input | 1 | Restart automatically after each burst |
| phase | output | 4 | Current phase within the burst |
| gate | output | 1 | Burst in progress |
| sel_n | output | 1 | Active-low peripheral select |
| pc_ce | output | 1 | 16-pulse program counter clock enable |
| reg_ce | output | 1 | 8-pulse register clock enable |
| tc | output | 1 | Terminal phase indication |
| t1 | output | 1 | First-phase carry-preset strobe |
| t0 | output | 1 | Post-burst load strobe |
| run | output | 1 | Inverse of t0 |

## Verification
The end of a burst and the start of the next can fall in the same cycle. This happens through a request held low in the terminal phase, or through free-run. In that cycle the gate must stay high, so `t0` from the old burst lines up with `t1` of the new one. The bench provokes both cases. It judges them by counting 32 or 48 contiguous `pc_ce` pulses with no gap, and by checking where `t0` and `t1` appear in the cycle.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             free_run,
  output logic [CNT_W-1:0] phase,
  output logic             gate,
  output logic             sel_n,
  output logic             pc_ce,
  output logic             reg_ce,
  output logic             tc,
  output logic             t1,
  output logic             t0,
  output logic             run
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             gate_q;
  logic             t0_q;
  logic             gate_d;

  assign tc     = gate_q && (cnt_q == LAST);
  assign gate_d = !start_n || (gate_q && !tc) || (tc && free_run);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
      t0_q   <= 1'b0;
    end else begin
      gate_q <= gate_d;
      cnt_q  <= gate_q ? cnt_q + 1'b1 : '0;
      t0_q   <= tc;
    end
  end

  assign phase  = cnt_q;
  assign gate   = gate_q;
  assign sel_n  = !gate_q;
  assign pc_ce  = gate_q;
  assign reg_ce = gate_q && !cnt_q[CNT_W-1];
  assign t1     = gate_q && (cnt_q == '0);
  assign t0     = t0_q;
  assign run    = !t0_q;

  // R1
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> phase == '0);
  // R2
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> (phase == '0) && t1 && !sel_n);
  // R4
  reg_in_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ce |-> pc_ce);
  // R6
  fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> t0);
  // R6
  strobe_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t0 |-> $past(phase) == LAST);
  // R8
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && start_n && !free_run) |=> !gate);
  // R10
  free_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && free_run) |=> gate && t1);
endmodule

// File: tb/test_burst_seq.sv
module test_burst_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n = 1'b1;
  logic       free_run = 1'b0;
  logic [3:0] phase;
  logic       gate, sel_n, pc_ce, reg_ce, tc, t1, t0, run;

  int checks = 0;
  int failures = 0;

  int npc, nreg, nt1, ntc, nt0, mism;
  int pc_first, pc_last, reg_first, reg_last, t1_first, tc_first, t0_first;

  burst_seq i_burst_seq (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .free_run(free_run),
    .phase(phase), .gate(gate), .sel_n(sel_n), .pc_ce(pc_ce), .reg_ce(reg_ce),
    .tc(tc), .t1(t1), .t0(t0), .run(run)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_n = 1'b0;
    @(negedge clk) start_n = 1'b1;
  endtask

  // samples n cycles starting at the current negedge (index 0)
  task automatic observe(int n, int s_lo, int s_hi, int fr_off);
    npc = 0; nreg = 0; nt1 = 0; ntc = 0; nt0 = 0; mism = 0;
    pc_first = -1; pc_last = -1; reg_first = -1; reg_last = -1;
    t1_first = -1; tc_first = -1; t0_first = -1;
    for (int i = 0; i < n; i++) begin
      if (pc_ce)  begin npc++;  if (pc_first < 0) pc_first = i;  pc_last = i; end
      if (reg_ce) begin nreg++; if (reg_first < 0) reg_first = i; reg_last = i; end
      if (t1) begin nt1++; if (t1_first < 0) t1_first = i; end
      if (tc) begin ntc++; if (tc_first < 0) tc_first = i; end
      if (t0) begin nt0++; if (t0_first < 0) t0_first = i; end
      if (run == t0 || sel_n == pc_ce) mism++;
      start_n = !(i >= s_lo && i < s_hi);
      if (i == fr_off) free_run = 1'b0;
      @(negedge clk);
    end
    start_n = 1'b1;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 gate", gate, 0);
    chk("R1 sel_n", sel_n, 1);
    chk("R1 phase", phase, 0);
    chk("R1 enables", pc_ce | reg_ce, 0);
    chk("R1 t0/run", {t0, run}, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after release", gate | pc_ce, 0);
  endtask

  task automatic test_single();
    pulse_start();
    chk("R2 first phase", phase, 0);
    chk("R2 sel_n low", sel_n, 0);
    observe(30, -1, -1, -1);
    chk("R3 pc pulses", npc, 16);
    chk("R3 pc contiguous", pc_last - pc_first + 1, 16);
    chk("R3 sel_n/run complements", mism, 0);
    chk("R4 reg pulses", nreg, 8);
    chk("R4 reg first", reg_first, 0);
    chk("R4 reg last", reg_last, 7);
    chk("R5 tc count", ntc, 1);
    chk("R5 tc position", tc_first, 15);
    chk("R6 t0 count", nt0, 1);
    chk("R6 t0 position", t0_first, 16);
    chk("R7 t1 count", nt1, 1);
    chk("R7 t1 position", t1_first, 0);
    chk("R8 idle after burst", gate, 0);
    observe(10, -1, -1, -1);
    chk("R8 stays idle", npc, 0);
  endtask

  task automatic test_mid_start();
    pulse_start();
    observe(30, 4, 9, -1);
    chk("R9 pc pulses with mid request", npc, 16);
    chk("R9 reg pulses with mid request", nreg, 8);
    chk("R9 t1 count", nt1, 1);
    chk("R9 idle after", gate, 0);
  endtask

  task automatic test_terminal_start();
    pulse_start();
    observe(40, 15, 16, -1);
    chk("R11 pc pulses back-to-back", npc, 32);
    chk("R11 pc contiguous", pc_last - pc_first + 1, 32);
    chk("R11 reg pulses", nreg, 16);
    chk("R11 t1 count", nt1, 2);
    chk("R11 t0 count", nt0, 2);
    chk("R11 t0 first", t0_first, 16);
    chk("R11 complements", mism, 0);
  endtask

  task automatic test_free_run();
    free_run = 1'b1;
    pulse_start();
    observe(56, -1, -1, 40);
    chk("R10 pc pulses", npc, 48);
    chk("R10 pc contiguous", pc_last - pc_first + 1, 48);
    chk("R10 tc count", ntc, 3);
    chk("R10 t1 count", nt1, 3);
    chk("R10 reg pulses", nreg, 24);
    chk("R10 stops", gate, 0);
  endtask

  initial begin
    #1000000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    test_single();
    test_mid_start();
    test_terminal_start();
    test_free_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule